// File: doc/BRIEF.md
# Infrared MIR Frame Transmitter

This block turns a stream of bytes into one serial infrared transmit line carrying a framed, bit-stuffed, pulse-shaped packet. A producer hands bytes over through a valid/ready handshake, and a marker on the final byte tells the block where the payload ends. The block wraps the payload between two flag octets and appends a 16-bit frame check sequence. While sending the payload and the check sequence it inserts a zero after every run of five ones. Each bit leaves as either a short pulse or a silent bit period.

Two timing strobes come from a divider outside the block. `bit_en` marks the start of each bit period. `sub_tick` runs four times as fast and coincides with `bit_en` on every fourth tick. A zero bit drives the line high from the start of its bit until the next sub-tick, which is one quarter of the bit. A one bit leaves the line low. One byte is held ahead of the shifter, so the producer has most of a byte period to supply the next byte.

Top module: `mir_tx`

## Requirements
- R1: A frame starts when a byte is accepted while the block is idle. Its first line bit appears at the next `bit_en`. The line then carries, in order: the flag octet 01111110, the payload, the 16-bit check sequence and the flag octet again.
- R2: Payload bytes are sent least-significant bit first, in the order they were accepted.
- R3: A zero bit raises `ir_tx` in the clock after the `bit_en` that starts it. `ir_tx` falls in the clock after the next `sub_tick`. `ir_tx` never rises except after a `bit_en`.
- R4: A one bit keeps `ir_tx` low for its whole bit period.
- R5: In the payload and the check sequence, a zero bit is inserted after every five consecutive ones. This also applies when the run ends the check sequence, in which case the zero comes before the closing flag.
- R6: The two flag octets are never stuffed.
- R7: The check sequence is a CRC over the payload bits with polynomial x^16+x^12+x^5+1, in the right-shifting form 0x8408, preset to 0xFFFF. It is sent inverted, low bit first. For the ASCII payload "123456789" it is 0x906E, so 0x6E goes out first.
- R8: After reset `ir_tx` is low and `s_ready` is high. Between frames the line carries no pulse.
- R9: `s_ready` is low while a flag, a stuffed bit or the check sequence is on the line. It is also low from the cycle after a byte marked last is accepted until the frame ends.
- R10: When the last bit of a byte is sent with no byte waiting and none handed over in that cycle, the payload ends. The check sequence and closing flag follow at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe at the start of each bit period |
| sub_tick | input | 1 | One-cycle strobe at four times the bit rate, coinciding with `bit_en` |
| s_valid | input | 1 | Producer has a byte on `s_data` |
| s_data | input | BYTE_W | Payload byte |
| s_last | input | 1 | Byte on `s_data` ends the payload |
| s_ready | output | 1 | Block accepts the byte this cycle |
| ir_tx | output | 1 | Infrared transmit line, high during a pulse |

## Verification
Several properties are checked on every cycle. A pulse always dies at the next sub-tick and only ever starts at a bit strobe. A stuffed bit always leaves as a pulse. The stuffing run is empty while the opening flag is sent. The handshake closes after a byte marked last.

The exact bit content of a frame can only be shown by the bench's scenarios. That covers LSB-first order, where stuffed zeros land (including the one before the closing flag) and the value of the check sequence. The bench's scenarios also cover idle gaps, early payload end and the phases in which `s_ready` must stay low. The bench rebuilds each expected line sequence from the payload alone and compares it bit by bit.

// File: rtl/mir_tx_pkg.sv
package mir_tx_pkg;

  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY_REV = 16'h8408;
  localparam logic [CRC_W-1:0] CRC_PRESET   = 16'hFFFF;
  localparam logic [7:0]       FLAG_OCTET   = 8'h7E;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_DATA,
    ST_FCS,
    ST_CLOSE
  } tx_state_e;

  // one serial CRC step, bit-at-a-time, right-shifting form
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return fb ? ((c >> 1) ^ CRC_POLY_REV) : (c >> 1);
  endfunction

  // run of ones that forces an inserted zero
  function automatic logic run_full(input int unsigned run, input int unsigned limit);
    return run == limit;
  endfunction

endpackage

// File: rtl/mir_tx_crc.sv
module mir_tx_crc
  import mir_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv,
  input  logic             din,
  output logic [CRC_W-1:0] crc_next
);
  logic [CRC_W-1:0] crc_q;

  always_comb crc_next = adv ? crc_step(crc_q, din) : crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     crc_q <= CRC_PRESET;
    else if (clear) crc_q <= CRC_PRESET;
    else            crc_q <= crc_next;
  end
endmodule

// File: rtl/mir_tx_stuff.sv
module mir_tx_stuff
  import mir_tx_pkg::*;
#(
  parameter int RUN_MAX = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic take,
  input  logic count,
  input  logic din,
  output logic stuff_now
);
  localparam int RW = $clog2(RUN_MAX + 1);
  logic [RW-1:0] run_q;

  always_comb stuff_now = run_full(run_q, RUN_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n || clear)    run_q <= '0;
    else if (take && stuff_now) run_q <= '0;
    else if (count)         run_q <= din ? run_q + 1'b1 : '0;
  end
endmodule

// File: rtl/mir_tx_shaper.sv
module mir_tx_shaper (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic sub_tick,
  input  logic send,
  input  logic zero,
  output logic ir_tx
);
  always_ff @(posedge clk) begin
    if (!rst_n)        ir_tx <= 1'b0;
    else if (bit_en)   ir_tx <= send && zero;
    else if (sub_tick) ir_tx <= 1'b0;
  end

  // R3: pulse lasts until the next sub-tick only
  a_r3_pulse_short: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_tick && !bit_en) |=> !ir_tx);
  // R3: a pulse only starts at a bit strobe
  a_r3_rise_at_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_tx) |-> $past(bit_en));
endmodule

// File: rtl/mir_tx.sv
module mir_tx
  import mir_tx_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int RUN_MAX = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              sub_tick,
  input  logic              s_valid,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic              ir_tx
);
  localparam int CNT_W = $clog2(CRC_W);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] LAST_FCS  = CNT_W'(CRC_W - 1);
  localparam logic [CNT_W-1:0] LAST_FLAG = CNT_W'(7);

  tx_state_e         state;
  logic [CNT_W-1:0]  bitcnt;
  logic [CRC_W-1:0]  sh;
  logic [BYTE_W-1:0] hold;
  logic              hold_full, hold_last, cur_last, last_in, stuff_cur;

  // named internal events
  logic accept, start, tick, stuff_now, tx_bit, data_bit, count_bit, crc_adv, more;
  logic [CRC_W-1:0] crc_next;

  always_comb begin
    s_ready   = !hold_full && !last_in && !stuff_cur &&
                (state == ST_IDLE || state == ST_DATA);
    accept    = s_valid && s_ready;
    start     = accept && state == ST_IDLE;
    tick      = bit_en && state != ST_IDLE;
    data_bit  = (bitcnt == '0) ? hold[0] : sh[0];
    more      = hold_full || accept;
    unique case (state)
      ST_OPEN, ST_CLOSE: tx_bit = FLAG_OCTET[bitcnt[2:0]];
      ST_DATA:           tx_bit = data_bit;
      ST_FCS:            tx_bit = sh[0];
      default:           tx_bit = 1'b1;
    endcase
    if (stuff_now && state != ST_IDLE) tx_bit = 1'b0;
    count_bit = tick && !stuff_now && (state == ST_DATA || state == ST_FCS);
    crc_adv   = tick && !stuff_now && state == ST_DATA;
  end

  mir_tx_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clear(start), .adv(crc_adv),
    .din(data_bit), .crc_next(crc_next)
  );

  mir_tx_stuff #(.RUN_MAX(RUN_MAX)) u_stuff (
    .clk(clk), .rst_n(rst_n), .clear(start), .take(tick),
    .count(count_bit), .din(tx_bit), .stuff_now(stuff_now)
  );

  mir_tx_shaper u_shape (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sub_tick(sub_tick),
    .send(tick), .zero(!tx_bit), .ir_tx(ir_tx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      sh        <= '0;
      hold      <= '0;
      hold_full <= 1'b0;
      hold_last <= 1'b0;
      cur_last  <= 1'b0;
      last_in   <= 1'b0;
      stuff_cur <= 1'b0;
    end else begin
      if (tick) begin
        stuff_cur <= stuff_now;
        if (!stuff_now) begin
          unique case (state)
            ST_OPEN: begin
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == LAST_FLAG) begin
                state  <= ST_DATA;
                bitcnt <= '0;
              end
            end
            ST_DATA: begin
              if (bitcnt == '0) begin
                sh        <= {{(CRC_W - BYTE_W + 1){1'b0}}, hold[BYTE_W-1:1]};
                cur_last  <= hold_last;
                hold_full <= 1'b0;
              end else begin
                sh <= sh >> 1;
              end
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == LAST_DATA) begin
                bitcnt <= '0;
                if (cur_last || !more) begin
                  state <= ST_FCS;
                  sh    <= ~crc_next;
                end
              end
            end
            ST_FCS: begin
              sh     <= sh >> 1;
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == LAST_FCS) begin
                state  <= ST_CLOSE;
                bitcnt <= '0;
              end
            end
            ST_CLOSE: begin
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == LAST_FLAG) begin
                state   <= ST_IDLE;
                bitcnt  <= '0;
                last_in <= 1'b0;
              end
            end
            default: ;
          endcase
        end
      end
      if (accept) begin
        hold      <= s_data;
        hold_full <= 1'b1;
        hold_last <= s_last;
        if (s_last) last_in <= 1'b1;
        if (state == ST_IDLE) begin
          state  <= ST_OPEN;
          bitcnt <= '0;
        end
      end
    end
  end

  // R9: no further byte once the last one is in
  a_r9_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && s_last) |=> !s_ready);
  // R5: an inserted bit always leaves as a pulse
  a_r5_stuff_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && stuff_now) |=> ir_tx);
  // R6: the opening flag never sees a pending insertion
  a_r6_flag_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OPEN) |-> !stuff_now);
endmodule

// File: tb/tb_mir_tx.sv
module tb_mir_tx;
  localparam int K_FLAG = 0, K_DATA = 1, K_FCS = 2, K_STUFF = 3, K_IDLE = 4;
  localparam int NV = 6;
  localparam logic [31:0] VDATA [NV] = '{32'h0000_00A5, 32'h7E00_FFFF, 32'h0000_0000,
                                         32'h001F_F83E, 32'hFFFF_FFFF, 32'h0000_0055};
  localparam int VLEN [NV] = '{1, 4, 2, 3, 4, 1};

  logic clk = 0, rst_n = 0, bit_en = 0, sub_tick = 0;
  logic s_valid = 0, s_last = 0;
  logic [7:0] s_data = 0;
  logic s_ready, ir_tx;

  mir_tx dut (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sub_tick(sub_tick),
              .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
              .s_ready(s_ready), .ir_tx(ir_tx));

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  logic [7:0] pay [0:15];
  logic exp_b [0:511];
  int   exp_k [0:511];
  int   exp_len;
  logic [15:0] exp_fcs;
  logic armed = 0, started = 0, prev_ir = 0;
  int   pos = 0, cur_k = K_IDLE, phase = 0;
  int   mism = 0, shape_bad = 0, idle_bad = 0, rdy_bad = 0;
  bit   done = 0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic b, input int k);
    exp_b[exp_len] = b;
    exp_k[exp_len] = k;
    exp_len++;
  endtask

  // expected line sequence, rebuilt from the payload
  task automatic build(input int n);
    logic [15:0] c;
    logic b;
    int run;
    exp_len = 0;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {8'h00, pay[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    exp_fcs = ~c;
    for (int k = 0; k < 8; k++) put((k != 0 && k != 7), K_FLAG);
    run = 0;
    for (int i = 0; i < n * 8 + 16; i++) begin
      b = (i < n * 8) ? pay[i / 8][i % 8] : exp_fcs[i - n * 8];
      put(b, (i < n * 8) ? K_DATA : K_FCS);
      run = b ? run + 1 : 0;
      if (run == 5) begin put(1'b0, K_STUFF); run = 0; end
    end
    for (int k = 0; k < 8; k++) put((k != 0 && k != 7), K_FLAG);
  endtask

  // strobes and line monitor
  initial begin
    @(posedge rst_n);
    forever begin
      @(posedge clk); #1;
      if (bit_en) begin
        if (!started && armed && ir_tx) begin started = 1; pos = 0; end
        if (started) begin
          if (pos < exp_len) begin
            if (ir_tx == exp_b[pos]) mism++;
            cur_k = exp_k[pos];
          end else begin
            if (ir_tx) idle_bad++;
            cur_k = K_IDLE;
          end
          pos++;
        end else if (ir_tx) idle_bad++;
      end else if (sub_tick) begin
        if (ir_tx) shape_bad++;
      end else if (ir_tx != prev_ir) shape_bad++;
      prev_ir = ir_tx;
      if (started && pos < exp_len && cur_k != K_DATA && s_ready) rdy_bad++;
      phase++;
      sub_tick = (phase % 4 == 0);
      bit_en   = (phase % 16 == 0);
    end
  end

  task automatic push(input logic [7:0] b, input logic l);
    @(negedge clk);
    s_valid = 1; s_data = b; s_last = l;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 0; s_last = 0;
    if (l) check(!s_ready, "R9 ready after last", s_ready, 0);
  endtask

  task automatic run_frame(input int n, input int nsend, input logic with_last, input string tag);
    build(n);
    started = 0; pos = 0; cur_k = K_IDLE;
    mism = 0; shape_bad = 0; idle_bad = 0; rdy_bad = 0;
    armed = 1;
    for (int i = 0; i < nsend; i++) push(pay[i], with_last && i == nsend - 1);
    while (!(started && pos >= exp_len + 2)) @(posedge clk);
    armed = 0;
    // R1 R2 R5 R6 R7 R10: bit-exact line content
    check(mism == 0, {tag, " R1/R2/R5 line bits"}, mism, 0);
    check(shape_bad == 0, {tag, " R3 R4 pulse shape"}, shape_bad, 0);
    check(rdy_bad == 0, {tag, " R9 ready in flag/stuff/fcs"}, rdy_bad, 0);
    check(idle_bad == 0, {tag, " R8 idle line"}, idle_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    check(ir_tx == 0, "R8 reset ir_tx", ir_tx, 0);
    check(s_ready == 1, "R8 reset ready", s_ready, 1);
    @(negedge clk); rst_n = 1;
    repeat (40) @(posedge clk);

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < VLEN[v]; i++) pay[i] = VDATA[v][8 * i +: 8];
      run_frame(VLEN[v], VLEN[v], 1'b1, $sformatf("vec%0d", v));
      repeat (37) @(posedge clk);
    end

    // R7 known check value for "123456789"
    for (int i = 0; i < 9; i++) pay[i] = 8'h31 + 8'(i);
    run_frame(9, 9, 1'b1, "ascii R7");
    check(exp_fcs == 16'h906E, "R7 fcs value", exp_fcs, 16'h906E);

    // R10 payload ends when no byte is waiting
    pay[0] = 8'hC3; pay[1] = 8'h0F;
    run_frame(2, 2, 1'b0, "R10 underrun");

    // R6 flag-like payload byte next to stuffing, back to back frames
    pay[0] = 8'h7E; pay[1] = 8'hFC;
    run_frame(2, 2, 1'b1, "R6 flaglike");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule